// File: doc/BRIEF.md
# PIO Strobe Sequencer

This block times one programmed-I/O read or write cycle toward a disk device on a parallel ATA-style bus. A request is taken while the block is idle. It then runs three phases counted in bus clocks. First an address/select setup phase. Then an active phase in which the read or write strobe is low. Then a hold/recovery phase. After that it returns to idle.

Each phase length comes from one timing byte. Two such bytes are supplied: one for accesses to the 16-bit data register and one for accesses to the command and control registers. A select input picks one of them for each request. The chosen byte, the direction, the width flag and the wait-enable flag are all latched when the request is accepted. Later changes on those inputs do not affect the access already running.

When waiting is enabled, the device's ready line can stretch the active phase. A narrow-port flag limits both the data driven and the data captured to the low byte. A one-cycle done pulse marks the final hold clock.

Top module: `pio_strobe_sequencer`

## Requirements
- R1: The setup phase lasts 1, 2, 3 or 4 clocks for timing-byte bits [7:6] = 0, 1, 2, 3. During setup `addr_valid_o` is high and both strobes are high.
- R2: With waiting disabled, the active phase lasts 2, 3, 4, 5, 6, 8, 12 or 16 clocks for timing-byte bits [2:0] = 0 through 7.
- R3: The hold phase lasts 1, 2, 3, 4, 5, 6, 8 or 12 clocks for timing-byte bits [5:3] = 0 through 7. During hold `addr_valid_o` is high and both strobes are high.
- R4: `data_port_i` = 1 times the access with `data_cfg_i`, and `data_port_i` = 0 times it with `ctrl_cfg_i`.
- R5: A request accepted at a clock edge starts setup in the very next cycle. Phases run in the order setup, active, hold. `busy_o` and `addr_valid_o` stay high throughout. Only the strobe for the access direction goes low (`dior_n_o` for reads, `diow_n_o` for writes), and only during active.
- R6: `start_i` is accepted only when idle. A start that is held high while busy, including during the done cycle, does not lengthen the access or begin a new one.
- R7: `done_o` is high for exactly one cycle, the last hold clock. In the next cycle `busy_o` is low.
- R8: When waiting was enabled at acceptance, an active phase of nominal length A ends after max(A, k) clocks, where k is the active cycle during which `iordy_i` is first seen high. When waiting is disabled, `iordy_i` has no effect.
- R9: For a read, `rdata_o` takes `dd_i` as sampled at the edge that ends the active phase, and holds that value until the next read. In narrow mode the upper byte of `rdata_o` is 0.
- R10: For a write, `dd_oe_o` is high and `dd_o` holds the accepted write word from the first setup clock through the last hold clock. In narrow mode the upper byte of `dd_o` is 0. For a read, `dd_oe_o` stays low.
- R11: After reset the block is idle: `busy_o`, `done_o`, `addr_valid_o`, `dd_oe_o` = 0, both strobes are 1, and `rdata_o` = 0.
- R12: Changes to the timing bytes, the select, the direction, the width flag, the wait flag or the write data after acceptance do not alter the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a cycle (taken only when idle) |
| is_write_i | input | 1 | 1 = write, 0 = read |
| data_port_i | input | 1 | 1 = data register access, 0 = command/control access |
| data_cfg_i | input | 8 | Timing byte for data-register accesses |
| ctrl_cfg_i | input | 8 | Timing byte for command/control accesses |
| iordy_en_i | input | 1 | Enable ready-line wait extension |
| narrow_i | input | 1 | 1 = 8-bit data port, 0 = 16-bit |
| wdata_i | input | 16 | Write data |
| iordy_i | input | 1 | Device ready line |
| dd_i | input | 16 | Data bus from device |
| dd_o | output | 16 | Data bus toward device |
| dd_oe_o | output | 1 | Data bus output enable |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| addr_valid_o | output | 1 | Address/select held valid for the whole cycle |
| rdata_o | output | 16 | Captured read data |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle pulse on the final hold clock |

## Verification
The hardest case to reach is the wait extension, because the ready line only matters at the last nominal active clock or later. A release that lands before that clock has to produce no extension at all. The stimulus counts strobe-low cycles as they happen and raises the ready line during a chosen active cycle. That cycle is drawn at random from before, at and well past the nominal length. In addition, the data bus is corrupted as soon as hold begins, which shows that capture happens exactly at the end of the active phase. The other inputs are scrambled right after acceptance, which shows that the latched request is the one in use.

// File: rtl/pio_seq_pkg.sv
// Shared types and timing-field decode for the PIO strobe sequencer.
// Assumes one 8-bit timing byte: [7:6] setup, [5:3] hold, [2:0] active.
package pio_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef struct packed {
        logic [7:0] timing;
        logic       write;
        logic       narrow;
        logic       wait_en;
    } req_t;

    // Setup clocks: linear 1..4.
    function automatic logic [4:0] setup_clocks(input logic [1:0] code);
        return {3'b000, code} + 5'd1;
    endfunction

    // Hold clocks: linear 1..6, then 8 and 12.
    function automatic logic [4:0] hold_clocks(input logic [2:0] code);
        case (code)
            3'd6:    return 5'd8;
            3'd7:    return 5'd12;
            default: return {2'b00, code} + 5'd1;
        endcase
    endfunction

    // Active clocks: linear 2..6, then 8, 12 and 16.
    function automatic logic [4:0] active_clocks(input logic [2:0] code);
        case (code)
            3'd5:    return 5'd8;
            3'd6:    return 5'd12;
            3'd7:    return 5'd16;
            default: return {2'b00, code} + 5'd2;
        endcase
    endfunction

endpackage

// File: rtl/pio_field_decode.sv
// Turns a latched timing byte into last-count values (length - 1) per phase.
// Purely combinational; assumes CNT_W bits hold the longest length minus one.
module pio_field_decode
    import pio_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [7:0]       timing_i,
    output logic [CNT_W-1:0] setup_last_o,
    output logic [CNT_W-1:0] active_last_o,
    output logic [CNT_W-1:0] hold_last_o
);

    // Map each field through its non-linear table and subtract one.
    always_comb begin
        setup_last_o  = CNT_W'(setup_clocks(timing_i[7:6]) - 5'd1);
        hold_last_o   = CNT_W'(hold_clocks(timing_i[5:3]) - 5'd1);
        active_last_o = CNT_W'(active_clocks(timing_i[2:0]) - 5'd1);
    end

endmodule

// File: rtl/pio_phase_fsm.sv
// Phase sequencer: idle -> setup -> active -> hold -> idle.
// A shared up-counter clears on each phase entry. Active waits at its last
// count until iordy_ok_i. Assumes the last-count inputs are stable while busy.
module pio_phase_fsm
    import pio_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             iordy_ok_i,
    input  logic [CNT_W-1:0] setup_last_i,
    input  logic [CNT_W-1:0] active_last_i,
    input  logic [CNT_W-1:0] hold_last_i,
    output phase_t           phase_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             done_o,
    output logic             busy_o
);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    // Is the counter at the final clock of the current phase?
    always_comb begin
        case (phase_q)
            PH_SETUP:  at_last = (cnt_q == setup_last_i);
            PH_ACTIVE: at_last = (cnt_q == active_last_i);
            PH_HOLD:   at_last = (cnt_q == hold_last_i);
            default:   at_last = 1'b0;
        endcase
    end

    // Next-phase logic and per-cycle event flags.
    always_comb begin
        phase_d   = phase_q;
        accept_o  = (phase_q == PH_IDLE) && start_i;
        capture_o = (phase_q == PH_ACTIVE) && at_last && iordy_ok_i;
        done_o    = (phase_q == PH_HOLD) && at_last;
        case (phase_q)
            PH_IDLE:   if (start_i)   phase_d = PH_SETUP;
            PH_SETUP:  if (at_last)   phase_d = PH_ACTIVE;
            PH_ACTIVE: if (capture_o) phase_d = PH_HOLD;
            PH_HOLD:   if (at_last)   phase_d = PH_IDLE;
            default:                  phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Phase counter: clear on change, count up, saturate at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (phase_d != phase_q)            cnt_q <= '0;
        else if (phase_q != PH_IDLE && !at_last) cnt_q <= cnt_q + 1'b1;
    end

    assign phase_o = phase_q;
    assign busy_o  = (phase_q != PH_IDLE);

    // R5: an accepted start always opens with setup.
    assert_start_opens_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && start_i) |=> (phase_o == PH_SETUP));

    // R6/R7: after done the block is idle even if start is held high.
    assert_no_restart_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (phase_o == PH_IDLE));

    // R8: once released at the last active count, hold follows immediately.
    assert_active_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACTIVE && cnt_q == active_last_i && iordy_ok_i) |=> (phase_o == PH_HOLD));

    // R3: hold never runs past its last count.
    assert_hold_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |-> (cnt_q <= hold_last_i));

endmodule

// File: rtl/pio_data_lane.sv
// Data path: latches the write word at acceptance, drives it while a write
// is busy, and captures the read word at the end of active. Upper lanes are
// zeroed in narrow mode. Assumes DATA_W and NARROW_W are multiples of 8.
module pio_data_lane #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_narrow_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              narrow_i,
    input  logic              drive_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] dd_i,
    output logic [DATA_W-1:0] dd_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] keep_live, keep_held;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    // Per-lane keep masks: lanes above the narrow width drop in narrow mode.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit LOW_LANE = (g * 8) < NARROW_W;
        assign keep_live[g*8 +: 8] = (LOW_LANE || !load_narrow_i) ? 8'hFF : 8'h00;
        assign keep_held[g*8 +: 8] = (LOW_LANE || !narrow_i)      ? 8'hFF : 8'h00;
    end

    // Latch the write word at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      wdata_q <= '0;
        else if (load_i) wdata_q <= wdata_i & keep_live;
    end

    // Capture the read word at the edge that ends the active phase.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (capture_i) rdata_q <= dd_i & keep_held;
    end

    assign dd_o    = drive_i ? wdata_q : '0;
    assign rdata_o = rdata_q;

    // R10: the driven word does not move while driving continues.
    assert_wdata_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_i && $past(drive_i)) |-> $stable(dd_o));

    // R9: a narrow capture leaves the upper bits zero.
    assert_narrow_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && narrow_i) |=> (rdata_o[DATA_W-1:NARROW_W] == '0));

endmodule

// File: rtl/pio_strobe_sequencer.sv
// Top: one PIO strobe cycle with per-port timing bytes. It latches the
// request at acceptance, decodes the phase lengths, sequences the phases
// and handles the data bus. Assumes iordy_i is already synchronised.
module pio_strobe_sequencer
    import pio_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NARROW_W   = 8,
    parameter int MAX_CLOCKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic              data_port_i,
    input  logic [7:0]        data_cfg_i,
    input  logic [7:0]        ctrl_cfg_i,
    input  logic              iordy_en_i,
    input  logic              narrow_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              iordy_i,
    input  logic [DATA_W-1:0] dd_i,
    output logic [DATA_W-1:0] dd_o,
    output logic              dd_oe_o,
    output logic              dior_n_o,
    output logic              diow_n_o,
    output logic              addr_valid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W = $clog2(MAX_CLOCKS);

    phase_t           phase;
    req_t             req_q;
    logic             accept, capture, busy, iordy_ok;
    logic [7:0]       live_timing;
    logic [CNT_W-1:0] setup_last, active_last, hold_last;

    // Choose the timing byte by target register group.
    assign live_timing = data_port_i ? data_cfg_i : ctrl_cfg_i;

    // Latch the whole request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= '0;
        else if (accept) req_q <= '{timing: live_timing, write: is_write_i,
                                    narrow: narrow_i, wait_en: iordy_en_i};
    end

    assign iordy_ok = !req_q.wait_en || iordy_i;

    pio_field_decode #(.CNT_W(CNT_W)) u_decode (
        .timing_i      (req_q.timing),
        .setup_last_o  (setup_last),
        .active_last_o (active_last),
        .hold_last_o   (hold_last)
    );

    pio_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .iordy_ok_i    (iordy_ok),
        .setup_last_i  (setup_last),
        .active_last_i (active_last),
        .hold_last_i   (hold_last),
        .phase_o       (phase),
        .accept_o      (accept),
        .capture_o     (capture),
        .done_o        (done_o),
        .busy_o        (busy)
    );

    pio_data_lane #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_data (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (accept),
        .load_narrow_i (narrow_i),
        .wdata_i       (wdata_i),
        .narrow_i      (req_q.narrow),
        .drive_i       (dd_oe_o),
        .capture_i     (capture && !req_q.write),
        .dd_i          (dd_i),
        .dd_o          (dd_o),
        .rdata_o       (rdata_o)
    );

    // Bus-side outputs decoded from the phase and the latched direction.
    always_comb begin
        busy_o       = busy;
        addr_valid_o = busy;
        dd_oe_o      = busy && req_q.write;
        dior_n_o     = !((phase == PH_ACTIVE) && !req_q.write);
        diow_n_o     = !((phase == PH_ACTIVE) && req_q.write);
    end

    // R5: the two strobes are never low together.
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n_o && !diow_n_o));

    // R5: a strobe is low only inside a selected cycle.
    assert_strobe_inside_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n_o || !diow_n_o) |-> addr_valid_o);

    // R10: the bus is driven only for a write in progress.
    assert_oe_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe_o |-> (busy_o && req_q.write));

    // R7: done is followed by an idle cycle.
    assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: tb/pio_strobe_sequencer_test.sv
// Self-checking bench: directed corner cases plus seeded random accesses.
module pio_strobe_sequencer_test;

    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, is_write_i = 1'b0, data_port_i = 1'b0;
    logic [7:0]  data_cfg_i = 8'h00, ctrl_cfg_i = 8'h00;
    logic        iordy_en_i = 1'b0, narrow_i = 1'b0, iordy_i = 1'b0;
    logic [15:0] wdata_i = '0, dd_i = '0;
    logic [15:0] dd_o, rdata_o;
    logic        dd_oe_o, dior_n_o, diow_n_o, addr_valid_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    pio_strobe_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
        .data_port_i(data_port_i), .data_cfg_i(data_cfg_i), .ctrl_cfg_i(ctrl_cfg_i),
        .iordy_en_i(iordy_en_i), .narrow_i(narrow_i), .wdata_i(wdata_i),
        .iordy_i(iordy_i), .dd_i(dd_i), .dd_o(dd_o), .dd_oe_o(dd_oe_o),
        .dior_n_o(dior_n_o), .diow_n_o(diow_n_o), .addr_valid_o(addr_valid_o),
        .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int exp_setup(input logic [7:0] b);
        return int'(b[7:6]) + 1;
    endfunction

    function automatic int exp_hold(input logic [7:0] b);
        int tbl [8] = '{1, 2, 3, 4, 5, 6, 8, 12};
        return tbl[b[5:3]];
    endfunction

    function automatic int exp_active(input logic [7:0] b);
        int tbl [8] = '{2, 3, 4, 5, 6, 8, 12, 16};
        return tbl[b[2:0]];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One access; rel = active cycle during which ready is raised (waiting only).
    task automatic run_access(input logic wr, input logic dport,
                              input logic [7:0] dcfg, input logic [7:0] ccfg,
                              input logic ien, input logic nar,
                              input logic [15:0] wd, input logic [15:0] rd,
                              input int rel, input bit hold_start);
        logic [7:0]  tb  = dport ? dcfg : ccfg;
        int          es  = exp_setup(tb);
        int          eh  = exp_hold(tb);
        int          ea  = exp_active(tb);
        logic [15:0] ew  = nar ? {8'h00, wd[7:0]} : wd;
        logic [15:0] er  = nar ? {8'h00, rd[7:0]} : rd;
        logic [15:0] prev_r;
        int ns = 0, na = 0, nh = 0, bad_strobe = 0, bad_order = 0, bad_bus = 0;
        bit seen_done = 0;
        if (ien && rel > ea) ea = rel;
        @(negedge clk);
        prev_r      = rdata_o;
        is_write_i  = wr;  data_port_i = dport;
        data_cfg_i  = dcfg; ctrl_cfg_i = ccfg;
        iordy_en_i  = ien; narrow_i = nar; wdata_i = wd; dd_i = rd;
        iordy_i     = ien ? (rel == 0) : 1'b0;
        start_i     = 1'b1;
        @(negedge clk);
        if (!hold_start) start_i = 1'b0;
        // R12: scramble every request input once the access is accepted
        data_cfg_i  = 8'($urandom);  ctrl_cfg_i = 8'($urandom);
        is_write_i  = ~wr; data_port_i = ~dport; narrow_i = ~nar;
        iordy_en_i  = ~ien; wdata_i = 16'($urandom);
        for (int k = 0; k < 200 && !seen_done; k++) begin
            logic stb = wr ? !diow_n_o : !dior_n_o;
            logic oth = wr ? !dior_n_o : !diow_n_o;
            if (oth) bad_strobe++;
            if (!addr_valid_o || !busy_o) bad_order++;
            if (stb) begin
                if (nh > 0) bad_order++;
                na++;
                if (ien && na >= rel) iordy_i = 1'b1;
            end else if (na == 0) begin
                ns++;
            end else begin
                nh++;
                dd_i = ~rd;   // R9: bus changes once active has ended
            end
            if (wr ? (!dd_oe_o || dd_o !== ew) : dd_oe_o) bad_bus++;
            if (done_o) begin
                seen_done = 1;
                if (stb || na == 0) bad_order++;
            end else begin
                @(negedge clk);
            end
        end
        check(seen_done, "R7", "done pulse seen", seen_done, 1);
        check(ns == es, dport ? "R1/R4 data" : "R1/R4 ctrl", "setup clocks", ns, es);
        check(na == ea, ien ? "R8" : "R2", "active clocks", na, ea);
        check(nh == eh, "R3", "hold clocks", nh, eh);
        check(bad_order == 0 && bad_strobe == 0, "R5", "phase/strobe errors", bad_order + bad_strobe, 0);
        check(bad_bus == 0, "R10", "bus drive errors", bad_bus, 0);
        @(negedge clk);
        start_i = 1'b0;
        check(!busy_o && !done_o, hold_start ? "R6" : "R7", "busy after done", busy_o, 0);
        if (!wr) check(rdata_o === er, "R9", "read data", rdata_o, er);
        else     check(rdata_o === prev_r, "R9", "read data kept on write", rdata_o, prev_r);
        iordy_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL R5 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_init = $urandom(32'h2B0D_51A7);
        if (seed_init == 0) ;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(!busy_o && !done_o && !addr_valid_o && !dd_oe_o, "R11", "idle flags", busy_o, 0);
        check(dior_n_o && diow_n_o, "R11", "strobes high", {dior_n_o, diow_n_o}, 3);
        check(rdata_o == 16'h0, "R11", "rdata cleared", rdata_o, 0);

        // Directed: mode-0/3/4 data bytes and default control byte (R1-R4)
        run_access(0, 1, 8'hF5, 8'hDE, 0, 0, 16'h0000, 16'hA55A, 0, 0);
        run_access(0, 1, 8'h09, 8'hDE, 0, 0, 16'h0000, 16'h1234, 0, 0);
        run_access(1, 1, 8'h00, 8'hDE, 0, 0, 16'hBEEF, 16'h0000, 0, 0);
        run_access(0, 0, 8'hF5, 8'hDE, 0, 0, 16'h0000, 16'h00C3, 0, 0);
        run_access(1, 0, 8'h00, 8'hFF, 0, 0, 16'h7777, 16'h0000, 0, 0);
        // R8: wait disabled with ready low -> no stretch
        run_access(0, 1, 8'h00, 8'h00, 0, 0, 16'h0, 16'h4321, 30, 0);
        // R8: release before, at, and after the nominal end
        run_access(0, 1, 8'h02, 8'h00, 1, 0, 16'h0, 16'h1111, 1, 0);
        run_access(0, 1, 8'h02, 8'h00, 1, 0, 16'h0, 16'h2222, 4, 0);
        run_access(1, 1, 8'h02, 8'h00, 1, 0, 16'h9999, 16'h0, 11, 0);
        // R9/R10: narrow read and write
        run_access(0, 1, 8'h4B, 8'h00, 0, 1, 16'h0, 16'hFACE, 0, 0);
        run_access(1, 1, 8'h4B, 8'h00, 0, 1, 16'hCAFE, 16'h0, 0, 0);
        // R6: start held through the whole access, including done
        run_access(0, 0, 8'h00, 8'h92, 0, 0, 16'h0, 16'h5A5A, 0, 1);
        run_access(1, 1, 8'hC7, 8'h00, 0, 0, 16'h0F0F, 16'h0, 0, 1);

        // Seeded random accesses
        for (int i = 0; i < 80; i++) begin
            logic ien = 1'($urandom);
            run_access(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                       ien, 1'($urandom), 16'($urandom), 16'($urandom),
                       int'($urandom_range(0, 20)), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule